// File: doc/BRIEF.md
# Transmit Sum Chain Bus Router

This block sits at one stage of a cascaded transmit summation chain. Four parallel sum buses, each carrying a complex (I and Q) partial sum, arrive from the previous stage. The block adds the complex samples of up to two channel sources, A and B, onto any subset of those buses. It then hands the four updated buses to the next stage. A 4-bit enable mask per source picks the buses that source joins. Source B is further gated by a multi-carrier mode input: when that input is low, B stays off every bus whatever its mask holds.

Source samples are 18-bit two's complement. They are sign-extended to the 26-bit bus width before being added. Addition wraps at the bus width, because saturation is left to the final scaling stage downstream. Every output is registered. A valid strobe travels alongside the data, delayed by the same single cycle. Masks and mode are applied to the sample presented in the same cycle as they are.

Top module: `txsum_router`

## Requirements
- R1: While reset is asserted and after it is released, `out_vld` is 0 and both outgoing buses are all zeros until the first valid sample is loaded.
- R2: `out_vld` equals `in_vld` delayed by exactly one clock cycle.
- R3: Bit n of `mask_a` adds source A's sign-extended I sample to outgoing I bus n and its Q sample to outgoing Q bus n. Bus n occupies bits [26n+25:26n] of each flat bus port.
- R4: With both masks equal to 0000, each outgoing bus equals its incoming partial sum one cycle later.
- R5: Every one of the 16 mask values is accepted. One source can feed several buses at once, and both sources can feed the same bus, where their sum is added.
- R6: When `cdma_en` is 0, source B adds nothing to any bus, for any value of `mask_b`.
- R7: Source samples are sign-extended from 18 to 26 bits, so a sample of 18'h3FFFF (-1) added to a zero partial sum yields 26'h3FFFFFF.
- R8: Sums wrap modulo 2^26 with no saturation (for example 26'h1FFFFFF + 1 gives 26'h2000000, and 26'h3FFFFFF + 1 gives 0).
- R9: While `in_vld` is 0, the outgoing buses hold their last loaded values, whatever the other inputs do.
- R10: The masks and mode bit present with a sample are the ones applied to that sample. A change takes effect on the very sample it accompanies, even on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input sample valid |
| a_i | input | 18 | Source A in-phase sample |
| a_q | input | 18 | Source A quadrature sample |
| b_i | input | 18 | Source B in-phase sample |
| b_q | input | 18 | Source B quadrature sample |
| mask_a | input | 4 | Bus enables for source A |
| mask_b | input | 4 | Bus enables for source B |
| cdma_en | input | 1 | Multi-carrier mode; permits source B |
| psum_i_in | input | 104 | Incoming I partial sums, four 26-bit buses |
| psum_q_in | input | 104 | Incoming Q partial sums, four 26-bit buses |
| out_vld | output | 1 | Output valid |
| psum_i_out | output | 104 | Outgoing I partial sums |
| psum_q_out | output | 104 | Outgoing Q partial sums |

## Verification
The assertions check four things on every cycle. The valid strobe must follow its input one cycle late. The buses must hold steady when no sample is offered. An all-zero mask must pass the incoming sums through unchanged. With the mode bit low, source B must vanish regardless of its mask. The arithmetic cannot be checked that way. Correct sign extension, wrap-around at the bus width, the sum of both sources on a shared bus, and per-sample mask changes on consecutive cycles only show up in the bench's directed and random scenarios. There, a model built from the requirements predicts every bus value.

// File: rtl/txsum_pkg.sv
package txsum_pkg;
   // Contribution sources of one router stage
   typedef enum logic {
      SRC_A = 1'b0,
      SRC_B = 1'b1
   } txsum_src_e;

   localparam int unsigned TXSUM_NUM_SRC = 2;
endpackage

// File: rtl/txsum_gate.sv
// Enables and widens one complex source sample for one bus.
module txsum_gate #(
   parameter int unsigned SRC_W = 18,
   parameter int unsigned BUS_W = 26
) (
   input  logic             en,
   input  logic [SRC_W-1:0] s_i,
   input  logic [SRC_W-1:0] s_q,
   output logic [BUS_W-1:0] g_i,
   output logic [BUS_W-1:0] g_q
);
   localparam int unsigned EXT_W = BUS_W - SRC_W;

   logic [BUS_W-1:0] wide_i;
   logic [BUS_W-1:0] wide_q;

   generate
      if (EXT_W > 0) begin : g_ext
         assign wide_i = {{EXT_W{s_i[SRC_W-1]}}, s_i};
         assign wide_q = {{EXT_W{s_q[SRC_W-1]}}, s_q};
      end else begin : g_same
         assign wide_i = s_i;
         assign wide_q = s_q;
      end
   endgenerate

   always_comb begin
      g_i = en ? wide_i : '0;
      g_q = en ? wide_q : '0;
   end
endmodule

// File: rtl/txsum_lane.sv
// One sum bus: incoming partial sum plus two gated terms, registered.
module txsum_lane #(
   parameter int unsigned BUS_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [BUS_W-1:0] pin_i,
   input  logic [BUS_W-1:0] pin_q,
   input  logic [BUS_W-1:0] ta_i,
   input  logic [BUS_W-1:0] ta_q,
   input  logic [BUS_W-1:0] tb_i,
   input  logic [BUS_W-1:0] tb_q,
   output logic [BUS_W-1:0] pout_i,
   output logic [BUS_W-1:0] pout_q
);
   logic [BUS_W-1:0] nxt_i;
   logic [BUS_W-1:0] nxt_q;

   // Modulo 2^BUS_W: carries out of the top bit are dropped.
   always_comb begin
      nxt_i = pin_i + ta_i + tb_i;
      nxt_q = pin_q + ta_q + tb_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pout_i <= '0;
         pout_q <= '0;
      end else if (ld) begin
         pout_i <= nxt_i;
         pout_q <= nxt_q;
      end
   end
endmodule

// File: rtl/txsum_router.sv
module txsum_router #(
   parameter int unsigned SRC_W   = 18,
   parameter int unsigned BUS_W   = 26,
   parameter int unsigned NUM_BUS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_vld,
   input  logic [SRC_W-1:0]         a_i,
   input  logic [SRC_W-1:0]         a_q,
   input  logic [SRC_W-1:0]         b_i,
   input  logic [SRC_W-1:0]         b_q,
   input  logic [NUM_BUS-1:0]       mask_a,
   input  logic [NUM_BUS-1:0]       mask_b,
   input  logic                     cdma_en,
   input  logic [NUM_BUS*BUS_W-1:0] psum_i_in,
   input  logic [NUM_BUS*BUS_W-1:0] psum_q_in,
   output logic                     out_vld,
   output logic [NUM_BUS*BUS_W-1:0] psum_i_out,
   output logic [NUM_BUS*BUS_W-1:0] psum_q_out
);
   import txsum_pkg::*;

   localparam int unsigned FLAT_W = NUM_BUS * BUS_W;

   initial begin
      assert (BUS_W >= SRC_W)
         else $error("txsum_router: BUS_W must not be narrower than SRC_W");
      assert (NUM_BUS >= 1)
         else $error("txsum_router: NUM_BUS must be at least 1");
      assert (TXSUM_NUM_SRC == 2)
         else $error("txsum_router: two sources expected");
   end

   // Source B is only allowed onto the chain in multi-carrier mode.
   logic [NUM_BUS-1:0] en_a;
   logic [NUM_BUS-1:0] en_b;

   always_comb begin
      en_a = mask_a;
      en_b = mask_b & {NUM_BUS{cdma_en}};
   end

   generate
      for (genvar n = 0; n < NUM_BUS; n++) begin : g_bus
         logic [BUS_W-1:0] ta_i, ta_q, tb_i, tb_q;

         txsum_gate #(.SRC_W(SRC_W), .BUS_W(BUS_W)) u_gate_a (
            .en  (en_a[n]),
            .s_i (a_i),
            .s_q (a_q),
            .g_i (ta_i),
            .g_q (ta_q)
         );

         txsum_gate #(.SRC_W(SRC_W), .BUS_W(BUS_W)) u_gate_b (
            .en  (en_b[n]),
            .s_i (b_i),
            .s_q (b_q),
            .g_i (tb_i),
            .g_q (tb_q)
         );

         txsum_lane #(.BUS_W(BUS_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (in_vld),
            .pin_i  (psum_i_in[n*BUS_W +: BUS_W]),
            .pin_q  (psum_q_in[n*BUS_W +: BUS_W]),
            .ta_i   (ta_i),
            .ta_q   (ta_q),
            .tb_i   (tb_i),
            .tb_q   (tb_q),
            .pout_i (psum_i_out[n*BUS_W +: BUS_W]),
            .pout_q (psum_q_out[n*BUS_W +: BUS_W])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) out_vld <= 1'b0;
      else        out_vld <= in_vld;
   end

   logic [FLAT_W-1:0] unused_w;
   assign unused_w = '0;
endmodule

// File: rtl/txsum_router_chk.sv
module txsum_router_chk #(
   parameter int unsigned NUM_BUS = 4,
   parameter int unsigned BUS_W   = 26
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_vld,
   input logic [NUM_BUS-1:0]       mask_a,
   input logic [NUM_BUS-1:0]       mask_b,
   input logic                     cdma_en,
   input logic [NUM_BUS*BUS_W-1:0] psum_i_in,
   input logic [NUM_BUS*BUS_W-1:0] psum_q_in,
   input logic                     out_vld,
   input logic [NUM_BUS*BUS_W-1:0] psum_i_out,
   input logic [NUM_BUS*BUS_W-1:0] psum_q_out
);
   // R2
   vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);

   // R2
   vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld);

   // R9
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> ($stable(psum_i_out) && $stable(psum_q_out)));

   // R4
   zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && mask_a == '0 && mask_b == '0)
      |=> (psum_i_out == $past(psum_i_in) && psum_q_out == $past(psum_q_in)));

   // R6
   b_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !cdma_en && mask_a == '0)
      |=> (psum_i_out == $past(psum_i_in) && psum_q_out == $past(psum_q_in)));
endmodule

bind txsum_router txsum_router_chk #(.NUM_BUS(NUM_BUS), .BUS_W(BUS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_vld     (in_vld),
   .mask_a     (mask_a),
   .mask_b     (mask_b),
   .cdma_en    (cdma_en),
   .psum_i_in  (psum_i_in),
   .psum_q_in  (psum_q_in),
   .out_vld    (out_vld),
   .psum_i_out (psum_i_out),
   .psum_q_out (psum_q_out)
);

// File: tb/sim_txsum_router.sv
module sim_txsum_router;
   localparam int SW = 18;
   localparam int BW = 26;
   localparam int NB = 4;
   localparam int FW = NB * BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_vld = 1'b0;
   logic [SW-1:0] a_i = '0, a_q = '0, b_i = '0, b_q = '0;
   logic [NB-1:0] mask_a = '0, mask_b = '0;
   logic          cdma_en = 1'b0;
   logic [FW-1:0] psum_i_in = '0, psum_q_in = '0;
   logic          out_vld;
   logic [FW-1:0] psum_i_out, psum_q_out;

   always #5 clk = ~clk;

   txsum_router u0 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
      .a_i(a_i), .a_q(a_q), .b_i(b_i), .b_q(b_q),
      .mask_a(mask_a), .mask_b(mask_b), .cdma_en(cdma_en),
      .psum_i_in(psum_i_in), .psum_q_in(psum_q_in),
      .out_vld(out_vld), .psum_i_out(psum_i_out), .psum_q_out(psum_q_out)
   );

   typedef struct {
      logic [FW-1:0] ei;
      logic [FW-1:0] eq;
      string         tag;
   } exp_t;

   exp_t          sb[$];
   exp_t          last_exp;
   int            n_chk = 0;
   int            n_bad = 0;
   bit            done = 0;

   function automatic logic [BW-1:0] sx(logic [SW-1:0] v);
      return {{(BW-SW){v[SW-1]}}, v};
   endfunction

   // Model from the requirements: bus n = psum n + A(mask_a[n]) + B(mask_b[n] & cdma)
   function automatic logic [FW-1:0] model(logic [FW-1:0] p, logic [SW-1:0] a,
                                           logic [SW-1:0] b, logic [NB-1:0] ma,
                                           logic [NB-1:0] mb, logic cd);
      logic [FW-1:0] r;
      for (int n = 0; n < NB; n++) begin
         logic [BW-1:0] s;
         s = p[n*BW +: BW];
         if (ma[n]) s = s + sx(a);
         if (mb[n] && cd) s = s + sx(b);
         r[n*BW +: BW] = s;
      end
      return r;
   endfunction

   task automatic check(string tag, logic [FW-1:0] act, logic [FW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic send(string tag, logic [SW-1:0] ai, logic [SW-1:0] aq,
                       logic [SW-1:0] bi, logic [SW-1:0] bq,
                       logic [NB-1:0] ma, logic [NB-1:0] mb, logic cd,
                       logic [FW-1:0] pi, logic [FW-1:0] pq);
      exp_t e;
      @(negedge clk);
      in_vld = 1'b1; a_i = ai; a_q = aq; b_i = bi; b_q = bq;
      mask_a = ma; mask_b = mb; cdma_en = cd; psum_i_in = pi; psum_q_in = pq;
      e.ei = model(pi, ai, bi, ma, mb, cd);
      e.eq = model(pq, aq, bq, ma, mb, cd);
      e.tag = tag;
      last_exp = e;
      sb.push_back(e);
   endtask

   task automatic idle(int cycles);
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         in_vld = 1'b0;
         a_i = SW'($urandom); a_q = SW'($urandom);
         b_i = SW'($urandom); b_q = SW'($urandom);
         mask_a = NB'($urandom); mask_b = NB'($urandom); cdma_en = 1'b1;
         psum_i_in = {4{BW'($urandom)}}; psum_q_in = {4{BW'($urandom)}};
      end
   endtask

   function automatic logic [FW-1:0] rnd_bus();
      logic [FW-1:0] r;
      for (int n = 0; n < NB; n++) r[n*BW +: BW] = BW'($urandom);
      return r;
   endfunction

   // Monitor: pops the scoreboard whenever the design presents a result
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_vld) begin
            if (sb.size() == 0) begin
               n_chk++; n_bad++;
               $display("FAIL R2: actual out_vld=1 expected out_vld=0");
            end else begin
               exp_t e;
               e = sb.pop_front();
               check({e.tag, " I"}, psum_i_out, e.ei);
               check({e.tag, " Q"}, psum_q_out, e.eq);
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 vld", {{(FW-1){1'b0}}, out_vld}, '0);
      check("R1 I", psum_i_out, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release Q", psum_q_out, '0);
      check("R1 after release vld", {{(FW-1){1'b0}}, out_vld}, '0);

      // R3: source A onto bus 0 only
      send("R3 A->bus0", 18'd100, 18'd7, 18'd55, 18'd9, 4'b0001, 4'b0000, 1'b1,
           {26'd4, 26'd3, 26'd2, 26'd1}, {26'd40, 26'd30, 26'd20, 26'd10});
      // R3: source A onto bus 2
      send("R3 A->bus2", 18'd1, 18'd2, 18'd0, 18'd0, 4'b0100, 4'b0000, 1'b0,
           rnd_bus(), rnd_bus());
      // R4: empty masks pass through
      send("R4 no bus", 18'd777, 18'd888, 18'd999, 18'd111, 4'b0000, 4'b0000, 1'b1,
           rnd_bus(), rnd_bus());
      // R5: A on all buses, B on bus1 and bus3
      send("R5 all+shared", 18'd1000, 18'd2000, 18'd30, 18'd40, 4'b1111, 4'b1010, 1'b1,
           rnd_bus(), rnd_bus());
      // R6: B blocked when mode off
      send("R6 B gated", 18'd5, 18'd6, 18'd123, 18'd321, 4'b0000, 4'b1111, 1'b0,
           rnd_bus(), rnd_bus());
      send("R6 B gated with A", 18'd5, 18'd6, 18'd123, 18'd321, 4'b0011, 4'b1111, 1'b0,
           rnd_bus(), rnd_bus());
      // R7: sign extension of -1 and most negative sample
      send("R7 sign ext", 18'h3FFFF, 18'h20000, 18'h3FFFF, 18'h20000, 4'b0001, 4'b0010, 1'b1,
           '0, '0);
      // R8: wrap at the bus width
      send("R8 wrap", 18'd1, 18'd1, 18'd1, 18'd1, 4'b0011, 4'b0000, 1'b1,
           {26'd0, 26'd0, 26'h3FFFFFF, 26'h1FFFFFF},
           {26'd0, 26'd0, 26'h1FFFFFF, 26'h3FFFFFF});
      // R9: hold while idle
      idle(3);
      @(negedge clk);
      check("R9 hold I", psum_i_out, last_exp.ei);
      check("R9 hold Q", psum_q_out, last_exp.eq);
      // R10: masks and mode change every cycle, back to back
      for (int k = 0; k < 16; k++)
         send("R10 per-sample", SW'($urandom), SW'($urandom), SW'($urandom), SW'($urandom),
              NB'(k), NB'(15 - k), k[0], rnd_bus(), rnd_bus());
      // R5: random patterns
      for (int k = 0; k < 40; k++)
         send("R5 random", SW'($urandom), SW'($urandom), SW'($urandom), SW'($urandom),
              NB'($urandom), NB'($urandom), 1'($urandom), rnd_bus(), rnd_bus());
      idle(4);
      // R2: every sample produced exactly one result
      check("R2 drained", FW'(sb.size()), '0);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule